// File: doc/BRIEF.md
# Control Cycle Timing Generator

This block produces every timing reference a sampled control loop needs. After reset it counts out a fixed startup interval, marks its end with a single-cycle configuration-done pulse, and only then starts running. A programmable prescaler makes a clock enable (`tick`), and a period timer steps on each tick from zero up to a programmed top value, then wraps.

Each timer period is one control cycle. Sampling pulses mark the ADC sampling instants, with up to eight of them spread evenly over the period. Only the first sample of a period starts a control cycle, which has four steps. First is acquisition, with a programmable conversion latency. A read phase follows: a start pulse and a level flag held for a programmable number of clock cycles. Then comes processing, which waits for a write-complete handshake from outside. The cycle ends with a data-valid pulse. The converter, the transfer engine and the processor are outside this block; they appear only as these delay settings and the one handshake input.

Top module: `cycle_timing_gen`

## Requirements
- R1: `cfgDonePulse` is high for exactly one cycle, in the STARTUP_LEN-th clock cycle after reset is released, and never again until the next reset.
- R2: During reset, and in every cycle up to and including the `cfgDonePulse` cycle, `timerVal` is 0 and `tick`, `samplePulse`, `adcDonePulse`, `readPulse`, `readActive` and `dataValidPulse` are all low.
- R3: Running begins in the cycle after `cfgDonePulse`. Number the running cycles from 0. `tick` is high in exactly those running cycles whose index modulo `prescDiv`+1 equals `prescDiv`.
- R4: `timerVal` starts at 0 in the first running cycle. It changes only after a tick cycle: to 0 if it equalled `periodVal`, otherwise to one more than before.
- R5: `osrSel` values 0, 1, 2 and 3 select N = 1, 2, 4 and 8 samples per period. Let S = max(1, floor((`periodVal`+1)/N)). `samplePulse` is high for one cycle, in the first cycle of each timer value k·S, for k = 0..N−1 with k·S ≤ `periodVal`.
- R6: Only the k = 0 sampling pulse starts a control cycle. `adcDonePulse` fires once, exactly max(1,`convLat`)·(`prescDiv`+1) cycles after that pulse. Sampling pulses with k > 0 have no effect on the phases.
- R7: `readPulse` is high for the one cycle after `adcDonePulse`. `readActive` is high for exactly max(1,`readCycles`) consecutive cycles, starting with the `readPulse` cycle.
- R8: Once the read phase has ended, `dataValidPulse` is high for the one cycle after the first clock edge that samples `wrDone` high. `wrDone` has no effect at any other time in the cycle.
- R9: A k = 0 sampling pulse that arrives before the current cycle has finished abandons that cycle, which produces no `dataValidPulse`, and starts a fresh acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescDiv | input | PRESC_W | Prescaler setting; tick rate is clk/(prescDiv+1) |
| periodVal | input | TMR_W | Top value of the period timer |
| osrSel | input | 2 | Oversampling select: N = 2^osrSel |
| convLat | input | LAT_W | Conversion latency in timer steps (0 acts as 1) |
| readCycles | input | RD_W | Read phase length in clock cycles (0 acts as 1) |
| wrDone | input | 1 | Write-complete handshake from outside |
| tick | output | 1 | Prescaler clock enable |
| timerVal | output | TMR_W | Period timer value |
| samplePulse | output | 1 | ADC sampling instant |
| adcDonePulse | output | 1 | Conversion results valid |
| readPulse | output | 1 | Start of read phase |
| readActive | output | 1 | Read phase in progress |
| dataValidPulse | output | 1 | New write data available |
| cfgDonePulse | output | 1 | End of startup configuration |

## Verification
The assertions assume that `prescDiv`, `periodVal`, `osrSel`, `convLat` and `readCycles` are held constant whenever reset is not asserted. Under that assumption the timer never passes `periodVal` and the phase order is fixed. The stimulus changes these settings only while reset is asserted, and it runs a fresh startup sequence for each configuration. It also chooses the latency, read length and write delay so that every completed cycle ends before the next period begins, except in the one cycle where the handshake is deliberately withheld to exercise the abort path. `wrDone` is driven only between clock edges, as a one-cycle pulse.

// File: rtl/cct_pkg.sv
package cct_pkg;

  // oversampling select width and the derived sample index width
  localparam int OSR_SEL_W    = 2;
  localparam int OSR_MAX_LOG2 = (1 << OSR_SEL_W) - 1;
  localparam int IDX_W        = OSR_MAX_LOG2 + 2;

  // strobes handed from the timing datapath to the phase control
  typedef struct packed {
    logic running;    // startup finished
    logic tick;       // prescaler enable
    logic stepFirst;  // first clock of the current timer value
    logic cycleStart; // first sampling instant of a period
  } cctStrobes_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACQ,
    PH_READ,
    PH_WAITWR,
    PH_VALID
  } cctPhase_e;

endpackage

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int TMR_W       = 16,
  parameter int STARTUP_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRESC_W-1:0]   prescDiv,
  input  logic [TMR_W-1:0]     periodVal,
  input  logic [OSR_SEL_W-1:0] osrSel,
  output logic                 cfgDonePulse,
  output logic                 tick,
  output logic [TMR_W-1:0]     timerVal,
  output logic                 samplePulse,
  output cctStrobes_t          strobes
);

  localparam int SU_W  = $clog2(STARTUP_LEN + 1);
  localparam int ACC_W = TMR_W + 1;

  logic               started;
  logic [SU_W-1:0]    suCnt;
  logic [PRESC_W-1:0] prescCnt;
  logic [ACC_W-1:0]   nextHit;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   osrN;
  logic [ACC_W-1:0]   span;
  logic [ACC_W-1:0]   spRaw;
  logic [ACC_W-1:0]   spacing;
  logic               stepFirst;
  logic               hit;
  logic               wrapNow;

  // startup sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      started <= 1'b0;
      suCnt   <= '0;
    end else if (!started) begin
      if (suCnt == SU_W'(STARTUP_LEN)) started <= 1'b1;
      else                             suCnt   <= suCnt + 1'b1;
    end
  end

  assign cfgDonePulse = !started && (suCnt == SU_W'(STARTUP_LEN));

  // prescaler
  always_ff @(posedge clk) begin
    if (!rstN || !started)        prescCnt <= '0;
    else if (prescCnt == prescDiv) prescCnt <= '0;
    else                           prescCnt <= prescCnt + 1'b1;
  end

  assign tick      = started && (prescCnt == prescDiv);
  assign stepFirst = started && (prescCnt == '0);
  assign wrapNow   = tick && (timerVal == periodVal);

  // period timer
  always_ff @(posedge clk) begin
    if (!rstN || !started) timerVal <= '0;
    else if (wrapNow)      timerVal <= '0;
    else if (tick)         timerVal <= timerVal + 1'b1;
  end

  // evenly spaced sampling instants
  assign osrN    = IDX_W'(1) << osrSel;
  assign span    = ACC_W'(periodVal) + ACC_W'(1);
  assign spRaw   = span >> osrSel;
  assign spacing = (spRaw == '0) ? ACC_W'(1) : spRaw;
  assign hit     = stepFirst && (ACC_W'(timerVal) == nextHit) && (hitIdx < osrN);

  always_ff @(posedge clk) begin
    if (!rstN || !started) begin
      nextHit <= '0;
      hitIdx  <= '0;
    end else if (wrapNow) begin
      nextHit <= '0;
      hitIdx  <= '0;
    end else if (hit) begin
      nextHit <= nextHit + spacing;
      hitIdx  <= hitIdx + 1'b1;
    end
  end

  assign samplePulse        = hit;
  assign strobes.running    = started;
  assign strobes.tick       = tick;
  assign strobes.stepFirst  = stepFirst;
  assign strobes.cycleStart = hit && (hitIdx == '0);

  // R1: configuration-done fires a single time
  p_cfg_once_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgDonePulse |=> (!cfgDonePulse && started));

  // R2: nothing moves before startup completes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (timerVal == '0 && !tick && !samplePulse));

  // R4: timer never passes its top value
  p_timer_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    timerVal <= periodVal);

  // R4: timer only steps on an enable
  p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (started && !tick) |=> $stable(timerVal));

  // R5: with a slowed prescaler a sampling pulse lasts one cycle
  p_sample_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (samplePulse && !tick) |=> !samplePulse);

endmodule

// File: rtl/cct_control.sv
module cct_control
  import cct_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cctStrobes_t      strobes,
  input  logic [LAT_W-1:0] convLat,
  input  logic [RD_W-1:0]  readCycles,
  input  logic             wrDone,
  output logic             adcDonePulse,
  output logic             readPulse,
  output logic             readActive,
  output logic             dataValidPulse
);

  cctPhase_e        phase;
  logic [LAT_W-1:0] latCnt;
  logic [RD_W-1:0]  rdCnt;
  logic [LAT_W-1:0] convEff;
  logic [RD_W-1:0]  rdEff;
  logic             adcHit;

  assign convEff = (convLat == '0) ? LAT_W'(1) : convLat;
  assign rdEff   = (readCycles == '0) ? RD_W'(1) : readCycles;
  assign adcHit  = (phase == PH_ACQ) && strobes.stepFirst && (latCnt == convEff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      latCnt <= '0;
      rdCnt  <= '0;
    end else if (strobes.cycleStart) begin
      // a new period always restarts acquisition
      phase  <= PH_ACQ;
      latCnt <= strobes.tick ? LAT_W'(1) : '0;
    end else begin
      unique case (phase)
        PH_ACQ: begin
          if (adcHit) begin
            phase <= PH_READ;
            rdCnt <= RD_W'(1);
          end else if (strobes.tick) begin
            latCnt <= latCnt + 1'b1;
          end
        end
        PH_READ: begin
          if (rdCnt >= rdEff) phase <= PH_WAITWR;
          else                rdCnt <= rdCnt + 1'b1;
        end
        PH_WAITWR: if (wrDone) phase <= PH_VALID;
        PH_VALID:  phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  assign adcDonePulse   = adcHit;
  assign readPulse      = (phase == PH_READ) && (rdCnt == RD_W'(1));
  assign readActive     = (phase == PH_READ);
  assign dataValidPulse = (phase == PH_VALID);

  // R2: phase outputs silent until running
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.running |-> !(adcDonePulse || readPulse || readActive || dataValidPulse));

  // R7: read start directly follows conversion done
  p_read_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (adcDonePulse && !strobes.cycleStart) |=> readPulse);

  // R7: the read start lies inside the read level
  p_read_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |-> readActive);

  // R8: data valid only after an accepted handshake
  p_valid_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataValidPulse |-> ($past(wrDone) && $past(phase == PH_WAITWR)));

  // R8: phase indications never overlap
  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcDonePulse, readActive, dataValidPulse}));

endmodule

// File: rtl/cycle_timing_gen.sv
module cycle_timing_gen
  import cct_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int TMR_W       = 16,
  parameter int LAT_W       = 8,
  parameter int RD_W        = 8,
  parameter int STARTUP_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRESC_W-1:0]   prescDiv,
  input  logic [TMR_W-1:0]     periodVal,
  input  logic [OSR_SEL_W-1:0] osrSel,
  input  logic [LAT_W-1:0]     convLat,
  input  logic [RD_W-1:0]      readCycles,
  input  logic                 wrDone,
  output logic                 tick,
  output logic [TMR_W-1:0]     timerVal,
  output logic                 samplePulse,
  output logic                 adcDonePulse,
  output logic                 readPulse,
  output logic                 readActive,
  output logic                 dataValidPulse,
  output logic                 cfgDonePulse
);

  cctStrobes_t strobes;

  cct_datapath #(
    .PRESC_W    (PRESC_W),
    .TMR_W      (TMR_W),
    .STARTUP_LEN(STARTUP_LEN)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .prescDiv    (prescDiv),
    .periodVal   (periodVal),
    .osrSel      (osrSel),
    .cfgDonePulse(cfgDonePulse),
    .tick        (tick),
    .timerVal    (timerVal),
    .samplePulse (samplePulse),
    .strobes     (strobes)
  );

  cct_control #(
    .LAT_W(LAT_W),
    .RD_W (RD_W)
  ) uControl (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .convLat       (convLat),
    .readCycles    (readCycles),
    .wrDone        (wrDone),
    .adcDonePulse  (adcDonePulse),
    .readPulse     (readPulse),
    .readActive    (readActive),
    .dataValidPulse(dataValidPulse)
  );

endmodule

// File: tb/cycle_timing_gen_test.sv
`timescale 1ns/1ps
module cycle_timing_gen_test;

  localparam int PRESC_W     = 16;
  localparam int TMR_W       = 16;
  localparam int LAT_W       = 8;
  localparam int RD_W        = 8;
  localparam int STARTUP_LEN = 16;
  localparam int NCYC        = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [PRESC_W-1:0] prescDiv = '0;
  logic [TMR_W-1:0]   periodVal = '0;
  logic [1:0]         osrSel = '0;
  logic [LAT_W-1:0]   convLat = '0;
  logic [RD_W-1:0]    readCycles = '0;
  logic               wrDone = 1'b0;
  logic               tick, samplePulse, adcDonePulse, readPulse;
  logic               readActive, dataValidPulse, cfgDonePulse;
  logic [TMR_W-1:0]   timerVal;

  cycle_timing_gen #(
    .PRESC_W(PRESC_W), .TMR_W(TMR_W), .LAT_W(LAT_W), .RD_W(RD_W),
    .STARTUP_LEN(STARTUP_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .prescDiv(prescDiv), .periodVal(periodVal),
    .osrSel(osrSel), .convLat(convLat), .readCycles(readCycles),
    .wrDone(wrDone), .tick(tick), .timerVal(timerVal),
    .samplePulse(samplePulse), .adcDonePulse(adcDonePulse),
    .readPulse(readPulse), .readActive(readActive),
    .dataValidPulse(dataValidPulse), .cfgDonePulse(cfgDonePulse)
  );

  always #2 clk = ~clk;

  typedef struct {int cyc; int val;} expItem_t;
  expItem_t qCfg[$], qSmp[$], qAdc[$], qRd[$], qVal[$];
  int  qWr[$];
  int  cyc = 0;
  int  checks = 0, fails = 0;
  bit  finished = 1'b0;
  bit  scnLive = 1'b0;
  int  c0 = 0, tT = 1, pP = 0, rdLen = 1, rdLeft = 0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic checkEq(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, nm, cyc, act, exp);
    end
  endtask

  // scoreboard compare for one pulse output against its queue
  task automatic checkPulse(input string req, input string nm, input logic seen,
                            input int act, input bit useVal, ref expItem_t q[$]);
    expItem_t it;
    if (q.size() > 0 && q[0].cyc < cyc) begin
      it = q.pop_front();
      checks++; fails++;
      $display("FAIL %s %s missing: actual=none expected=cycle %0d", req, nm, it.cyc);
    end
    if (seen) begin
      checks++;
      if (q.size() > 0 && q[0].cyc == cyc && (!useVal || q[0].val == act)) begin
        void'(q.pop_front());
      end else begin
        fails++;
        $display("FAIL %s %s unexpected at cycle %0d: actual=%0d expected=%0d",
                 req, nm, cyc, act, (q.size() > 0) ? q[0].cyc : -1);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && scnLive) begin
      int  expTmr;
      bit  expTick;
      bit  expRa;
      if (cyc <= c0) begin
        expTmr  = 0;
        expTick = 1'b0;
      end else begin
        expTmr  = ((cyc - c0 - 1) / tT) % (pP + 1);
        expTick = (((cyc - c0 - 1) % tT) == tT - 1);
      end
      checkEq("R3", "tick", int'(tick), int'(expTick));
      checkEq("R4", "timerVal", int'(timerVal), expTmr);
      checkPulse("R1", "cfgDonePulse", cfgDonePulse, 0, 1'b0, qCfg);
      checkPulse("R5", "samplePulse", samplePulse, int'(timerVal), 1'b1, qSmp);
      checkPulse("R6", "adcDonePulse", adcDonePulse, 0, 1'b0, qAdc);
      if (qRd.size() > 0 && qRd[0].cyc == cyc) rdLeft = rdLen;
      checkPulse("R7", "readPulse", readPulse, 0, 1'b0, qRd);
      expRa = (rdLeft > 0);
      checkEq("R7", "readActive", int'(readActive), int'(expRa));
      if (rdLeft > 0) rdLeft--;
      checkPulse("R8", "dataValidPulse", dataValidPulse, 0, 1'b0, qVal);
    end
  end

  task automatic runScenario(input int d, input int p, input int osr, input int lat,
                             input int rdc, input int w, input bit skip0, input bit stray);
    int leff, reff, sp, nOsr, base, adc, wt, endC;
    scnLive = 1'b0;
    rstN    = 1'b0;
    wrDone  = 1'b0;
    prescDiv   = PRESC_W'(d);
    periodVal  = TMR_W'(p);
    osrSel     = 2'(osr);
    convLat    = LAT_W'(lat);
    readCycles = RD_W'(rdc);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R2: reset state of every output
    checkEq("R2", "reset outputs",
            int'({tick, samplePulse, adcDonePulse, readPulse, readActive,
                  dataValidPulse, cfgDonePulse}) + int'(timerVal), 0);

    leff = (lat == 0) ? 1 : lat;
    reff = (rdc == 0) ? 1 : rdc;
    nOsr = 1 << osr;
    sp   = (p + 1) >> osr;
    if (sp == 0) sp = 1;
    c0 = STARTUP_LEN; tT = d + 1; pP = p; rdLen = reff; rdLeft = 0;
    qCfg.push_back('{c0, 0});
    for (int c = 0; c < NCYC; c++) begin
      base = c0 + 1 + c * (p + 1) * tT;
      if (stray && c == 0) qWr.push_back(base + 1); // R8: ignored during acquisition
      for (int k = 0; k < nOsr && k * sp <= p; k++)
        qSmp.push_back('{base + k * sp * tT, k * sp});
      adc = base + leff * tT;
      qAdc.push_back('{adc, 0});
      qRd.push_back('{adc + 1, 0});
      wt = adc + 1 + reff;
      if (!(skip0 && c == 0)) begin
        qWr.push_back(wt + w);
        qVal.push_back('{wt + w + 1, 0});
      end
    end
    endC = c0 + NCYC * (p + 1) * tT;

    #1 rstN = 1'b1;
    scnLive = 1'b1;
    while (cyc < endC) begin
      @(negedge clk);
      #1;
      wrDone = (qWr.size() > 0 && qWr[0] == cyc);
      if (wrDone) void'(qWr.pop_front());
    end
    wrDone = 1'b0;
    checkEq("R1", "cfg pulses left", qCfg.size(), 0);
    checkEq("R5", "sample pulses left", qSmp.size(), 0);
    checkEq("R6", "adc pulses left", qAdc.size(), 0);
    checkEq("R7", "read pulses left", qRd.size(), 0);
    checkEq("R8", "valid pulses left", qVal.size(), 0);
    qCfg.delete(); qSmp.delete(); qAdc.delete(); qRd.delete(); qVal.delete(); qWr.delete();
    scnLive = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    // uneven span: 11 steps, 4 samples at 0,2,4,6 (R5), full-rate prescaler
    runScenario(0, 10, 2, 3, 2, 1, 1'b0, 1'b0);
    // slowed prescaler, single sample, stray handshake during acquisition (R8)
    runScenario(2, 7, 0, 2, 4, 0, 1'b0, 1'b1);
    // zero latency and zero read length clamp to 1; first cycle abandoned (R9)
    runScenario(1, 4, 3, 0, 0, 2, 1'b1, 1'b0);
    // k=1 sample coincides with read start and must not restart (R6)
    runScenario(0, 11, 1, 5, 3, 0, 1'b0, 1'b0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

endmodule